// File: doc/BRIEF.md
# PWM Channel with Clearable Reference

This block is one timer output channel. A free-running up-counter steps from zero to a programmable period limit and then wraps. At each wrap it raises a one-cycle update pulse and copies the period limit and the compare threshold from their inputs into working copies, so a new setting only takes effect at a period boundary. The channel compares the counter with the threshold and drives a registered reference waveform. Four modes are available: two forced levels and two compare-driven modes.

A clear request can pull the reference low in the compare-driven modes. The request comes from one of two sources, selected by one bit. The first is a direct clear pin. The second is an external trigger pin, which passes through an optional inversion and a digital filter that needs a selectable number of consecutive equal samples. Once a clear lands, a latch keeps the reference low for the rest of the current period. The latch releases only at the next wrap, and only if the request has gone away by then. The trigger path has no prescaler and is never used as a clock.

Top module: `pwmc_channel`

## Requirements
- R1: The counter counts up by one each clock from 0 to the working period limit, then returns to 0. The period limit and compare threshold inputs are copied into the working values only in the cycle the counter wraps. After reset the working values are 0, so the first wrap happens on the first clock.
- R2: `update_o` is high for exactly one cycle: the first cycle in which the counter is 0 after a wrap. It is low during reset.
- R3: The reference is registered and shows the compare result of the counter value one cycle earlier. In mode 2'b10 it is high while the counter is below the threshold. In mode 2'b11 it is high while the counter is at or above the threshold.
- R4: Mode 2'b00 drives the reference low and mode 2'b01 drives it high. Neither forced mode reacts to the clear request, and neither sets the clear latch.
- R5: In modes 2'b10 and 2'b11, when the clear enable is 1 and the selected clear request is high, the reference is low on the next cycle.
- R6: A clear holds the reference low until the wrap that ends the current period, even if the request falls earlier. The release takes effect from the cycle that shows counter value 0. If the request is still high at the wrap, the reference stays low into the new period.
- R7: With the clear enable at 0, the reference follows the compare result and ignores both clear sources.
- R8: When the source select is 0, the clear request is the direct clear pin. When it is 1, the request is the filtered trigger, and the direct pin has no effect.
- R9: When the polarity bit is 1, the trigger pin is inverted before it is filtered.
- R10: The trigger is sampled into one register. The filtered level changes only after the sampled level has differed from it on N consecutive clocks, with N = 1 << filter select (1, 2, 4 or 8). A shorter excursion is ignored.
- R11: When the threshold is above the period limit (full duty), the reference is high on every cycle. A cleared reference becomes high again in the first cycle after the overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | CNT_W | Period limit; loaded into the working copy at wrap |
| thresh_i | input | CNT_W | Compare threshold; loaded into the working copy at wrap |
| mode_i | input | 2 | 00 forced low, 01 forced high, 10 high below threshold, 11 high at or above threshold |
| clr_en_i | input | 1 | Clear enable |
| clr_sel_i | input | 1 | Clear source: 0 direct pin, 1 filtered trigger |
| trig_i | input | 1 | Raw external trigger pin |
| trig_inv_i | input | 1 | Inverts the trigger before filtering |
| filt_sel_i | input | FSEL_W | Filter length select, N = 1 << value |
| clr_pin_i | input | 1 | Direct clear request |
| ref_o | output | 1 | Reference waveform |
| update_o | output | 1 | One-cycle update pulse after each wrap |

## Verification
The bound checker watches on every cycle that the counter never passes the working period limit and that each update pulse lines up with counter value 0. It also checks that the forced modes set the right level whatever the clear inputs do, that an enabled clear in a compare mode lowers the reference on the next cycle, and that the clear latch never drops in the middle of a period. Some behaviour only the bench scenarios can show, compared cycle by cycle with a behavioural model: the full-duty recovery at overflow, the rejection of short trigger glitches by the filter, the polarity inversion, source selection, and the clear enable at 0.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
   typedef enum logic [1:0] {
      MODE_FORCE_LO = 2'b00,
      MODE_FORCE_HI = 2'b01,
      MODE_BELOW    = 2'b10,
      MODE_ABOVE    = 2'b11
   } pwmc_mode_e;

   function automatic logic mode_is_forced(input logic [1:0] m);
      return !m[1];
   endfunction
endpackage

// File: rtl/pwmc_counter.sv
module pwmc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] thresh_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] thr_o,
   output logic             wrap_o,
   output logic             upd_o
);
   logic [CNT_W-1:0] cnt_q, per_q, thr_q;
   logic             upd_q;

   assign wrap_o = (cnt_q == per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         thr_q <= '0;
         upd_q <= 1'b0;
      end else begin
         upd_q <= wrap_o;
         if (wrap_o) begin
            cnt_q <= '0;
            per_q <= period_i;
            thr_q <= thresh_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign per_o = per_q;
   assign thr_o = thr_q;
   assign upd_o = upd_q;
endmodule

// File: rtl/pwmc_trig_filter.sv
module pwmc_trig_filter #(
   parameter int FSEL_W      = 2,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              inv_i,
   input  logic [FSEL_W-1:0] fsel_i,
   output logic              filt_o
);
   localparam int MAX_LOG = (1 << FSEL_W) - 1;
   localparam int RUN_W   = (MAX_LOG < 1) ? 1 : MAX_LOG;

   logic              pol;
   logic              samp;
   logic              filt_q;
   logic [RUN_W-1:0]  run_q;
   logic [RUN_W-1:0]  limit;

   assign pol = trig_i ^ inv_i;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= pol;
         end
         assign samp = s_q;
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= {ch_q[SYNC_STAGES-2:0], pol};
         end
         assign samp = ch_q[SYNC_STAGES-1];
      end
   endgenerate

   always_comb begin
      limit = '0;
      for (int i = 0; i < RUN_W; i++)
         if (i < int'(fsel_i)) limit[i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_q <= 1'b0;
         run_q  <= '0;
      end else if (samp == filt_q) begin
         run_q <= '0;
      end else if (run_q == limit) begin
         filt_q <= samp;
         run_q  <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign filt_o = filt_q;
endmodule

// File: rtl/pwmc_ref_gen.sv
module pwmc_ref_gen
   import pwmc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic             clr_en_i,
   input  logic             clr_req_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             ref_o,
   output logic             lat_o
);
   logic forced, raw, hit, eff, ref_d;
   logic ref_q, lat_q;

   always_comb begin
      forced = mode_is_forced(mode_i);
      unique case (pwmc_mode_e'(mode_i))
         MODE_FORCE_LO: raw = 1'b0;
         MODE_FORCE_HI: raw = 1'b1;
         MODE_BELOW:    raw = (cnt_i <  thr_i);
         MODE_ABOVE:    raw = (cnt_i >= thr_i);
         default:       raw = 1'b0;
      endcase
      hit   = clr_en_i && !forced && clr_req_i;
      eff   = clr_en_i && !forced && (lat_q || clr_req_i);
      ref_d = forced ? raw : (raw && !eff);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
         lat_q <= 1'b0;
      end else begin
         ref_q <= ref_d;
         if (hit)         lat_q <= 1'b1;
         else if (wrap_i) lat_q <= 1'b0;
      end
   end

   assign ref_o = ref_q;
   assign lat_o = lat_q;
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
   parameter int CNT_W       = 8,
   parameter int FSEL_W      = 2,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  thresh_i,
   input  logic [1:0]        mode_i,
   input  logic              clr_en_i,
   input  logic              clr_sel_i,
   input  logic              trig_i,
   input  logic              trig_inv_i,
   input  logic [FSEL_W-1:0] filt_sel_i,
   input  logic              clr_pin_i,
   output logic              ref_o,
   output logic              update_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("pwmc_channel: CNT_W must be at least 2");
      end
      if (FSEL_W < 1 || FSEL_W > 3) begin : g_bad_fsel
         $error("pwmc_channel: FSEL_W must be 1 to 3");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("pwmc_channel: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt, per, thr;
   logic             wrap, filt, clr_req, clr_lat;

   pwmc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .thresh_i(thresh_i),
      .cnt_o(cnt), .per_o(per), .thr_o(thr), .wrap_o(wrap), .upd_o(update_o)
   );

   pwmc_trig_filter #(.FSEL_W(FSEL_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .inv_i(trig_inv_i),
      .fsel_i(filt_sel_i), .filt_o(filt)
   );

   assign clr_req = clr_sel_i ? filt : clr_pin_i;

   pwmc_ref_gen #(.CNT_W(CNT_W)) u_ref (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clr_en_i(clr_en_i),
      .clr_req_i(clr_req), .wrap_i(wrap), .cnt_i(cnt), .thr_i(thr),
      .ref_o(ref_o), .lat_o(clr_lat)
   );
endmodule

// File: rtl/pwmc_channel_chk.sv
module pwmc_channel_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             clr_en_i,
   input logic             ref_o,
   input logic             update_o,
   input logic             clr_req,
   input logic             clr_lat,
   input logic             wrap,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per
);
   p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per);

   p_upd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      update_o |-> (cnt == '0));

   p_force_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b00) |=> !ref_o);

   p_force_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'b01) |=> ref_o);

   p_clear_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && clr_req && mode_i[1]) |=> !ref_o);

   p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_lat && !wrap) |=> clr_lat);
endmodule

bind pwmc_channel pwmc_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .clr_en_i(clr_en_i),
   .ref_o(ref_o), .update_o(update_o), .clr_req(clr_req),
   .clr_lat(clr_lat), .wrap(wrap), .cnt(cnt), .per(per)
);

// File: tb/pwmc_channel_test.sv
module pwmc_channel_test;
   localparam int CNT_W  = 8;
   localparam int FSEL_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CNT_W-1:0]  period_i = 8'd9;
   logic [CNT_W-1:0]  thresh_i = 8'd4;
   logic [1:0]        mode_i = 2'b10;
   logic              clr_en_i = 1'b0;
   logic              clr_sel_i = 1'b0;
   logic              trig_i = 1'b0;
   logic              trig_inv_i = 1'b0;
   logic [FSEL_W-1:0] filt_sel_i = '0;
   logic              clr_pin_i = 1'b0;
   logic              ref_o, update_o;

   always #2 clk = ~clk;

   pwmc_channel #(.CNT_W(CNT_W), .FSEL_W(FSEL_W)) uut (
      .clk(clk), .rst_n(rst_n), .period_i(period_i), .thresh_i(thresh_i),
      .mode_i(mode_i), .clr_en_i(clr_en_i), .clr_sel_i(clr_sel_i),
      .trig_i(trig_i), .trig_inv_i(trig_inv_i), .filt_sel_i(filt_sel_i),
      .clr_pin_i(clr_pin_i), .ref_o(ref_o), .update_o(update_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_cnt, m_per, m_thr, m_run;
   bit m_upd, m_ref, m_lat, m_s, m_f;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 0; m_thr = 0; m_run = 0;
         m_upd = 0; m_ref = 0; m_lat = 0; m_s = 0; m_f = 0;
      end else begin
         automatic bit wrap    = (m_cnt == m_per);
         automatic bit req     = clr_sel_i ? m_f : clr_pin_i;
         automatic bit forced  = (mode_i < 2);
         automatic bit raw;
         automatic int n       = 1 << filt_sel_i;
         case (mode_i)
            2'd0: raw = 0;
            2'd1: raw = 1;
            2'd2: raw = (m_cnt < m_thr);
            default: raw = (m_cnt >= m_thr);
         endcase
         if (forced) m_ref = raw;
         else m_ref = raw && !(clr_en_i && (m_lat || req));
         if (clr_en_i && !forced && req) m_lat = 1;
         else if (wrap) m_lat = 0;
         if (m_s == m_f) m_run = 0;
         else if (m_run == n - 1) begin m_f = m_s; m_run = 0; end
         else m_run = m_run + 1;
         m_s = trig_i ^ trig_inv_i;
         m_upd = wrap;
         if (wrap) begin m_cnt = 0; m_per = period_i; m_thr = thresh_i; end
         else m_cnt = m_cnt + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check({cur_req, " model ref"}, ref_o, m_ref);
         check("R2 model update", update_o, m_upd);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_upd();
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (update_o) break;
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int ups;
      tick(1);
      check("R1 reset ref", ref_o, 1'b0);
      check("R2 reset update", update_o, 1'b0);
      tick(2);
      rst_n = 1'b1;

      // R1 R2 R3: mode below-threshold
      cur_req = "R3";
      tick(12);
      ups = 0;
      for (int i = 0; i < 20; i++) begin tick(1); ups += update_o; end
      check("R2 two pulses per 20 cycles", ups == 2, 1'b1);
      // R1: new period loads at wrap
      cur_req = "R1";
      period_i = 8'd5;
      wait_upd(); wait_upd();
      ups = 0;
      for (int i = 0; i < 12; i++) begin tick(1); ups += update_o; end
      check("R1 period 6 gives two pulses", ups == 2, 1'b1);
      period_i = 8'd9;
      wait_upd(); wait_upd();

      // R3: at-or-above mode
      cur_req = "R3";
      mode_i = 2'b11;
      wait_upd(); wait_upd();
      tick(2); check("R3 above mode low at cnt1", ref_o, 1'b0);
      tick(5); check("R3 above mode high at cnt6", ref_o, 1'b1);

      // R4: forced modes ignore clear
      cur_req = "R4";
      clr_en_i = 1'b1; clr_pin_i = 1'b1;
      mode_i = 2'b01; tick(4); check("R4 forced high", ref_o, 1'b1);
      mode_i = 2'b00; tick(4); check("R4 forced low", ref_o, 1'b0);
      mode_i = 2'b01; tick(3); check("R4 forced high again", ref_o, 1'b1);
      clr_pin_i = 1'b0;

      // R5 R6: clear pulse held to next update
      cur_req = "R6";
      mode_i = 2'b10; thresh_i = 8'd8;
      wait_upd(); wait_upd();
      tick(2);
      clr_pin_i = 1'b1; tick(1); clr_pin_i = 1'b0;
      check("R5 cleared next cycle", ref_o, 1'b0);
      tick(3); check("R6 held low after request fell", ref_o, 1'b0);
      wait_upd(); tick(1);
      check("R6 released after wrap", ref_o, 1'b1);
      // R6: request still high at wrap keeps it low
      tick(3); clr_pin_i = 1'b1;
      wait_upd(); tick(1);
      check("R6 still low into new period", ref_o, 1'b0);
      clr_pin_i = 1'b0;
      wait_upd(); tick(1);
      check("R6 released once request gone", ref_o, 1'b1);

      // R7: enable off
      cur_req = "R7";
      clr_en_i = 1'b0; clr_pin_i = 1'b1;
      wait_upd(); tick(3);
      check("R7 clear ignored when disabled", ref_o, 1'b1);
      clr_pin_i = 1'b0; clr_en_i = 1'b1;
      wait_upd();

      // R8: source select
      cur_req = "R8";
      clr_sel_i = 1'b1; clr_pin_i = 1'b1;
      wait_upd(); tick(3);
      check("R8 direct pin ignored when trigger selected", ref_o, 1'b1);
      clr_sel_i = 1'b0; tick(1);
      check("R8 direct pin clears when selected", ref_o, 1'b0);
      clr_pin_i = 1'b0; clr_sel_i = 1'b1;
      wait_upd(); wait_upd();

      // R10: filter rejects short glitch
      cur_req = "R10";
      filt_sel_i = 2'd3;
      wait_upd(); tick(1);
      trig_i = 1'b1; tick(4); trig_i = 1'b0;
      tick(2); check("R10 short glitch ignored", ref_o, 1'b1);
      wait_upd(); tick(1);
      trig_i = 1'b1; tick(7);
      check("R10 not yet filtered after 7", ref_o, 1'b1);
      tick(3); check("R10 cleared after 8 samples", ref_o, 1'b0);
      trig_i = 1'b0;
      wait_upd(); wait_upd(); wait_upd();

      // R9: polarity inversion
      cur_req = "R9";
      filt_sel_i = 2'd0;
      wait_upd(); tick(1);
      trig_inv_i = 1'b1; tick(4);
      check("R9 inverted low trigger clears", ref_o, 1'b0);
      trig_inv_i = 1'b0;
      wait_upd(); wait_upd(); wait_upd(); tick(1);
      check("R9 released after polarity restored", ref_o, 1'b1);
      clr_sel_i = 1'b0;

      // R11: full duty recovery
      cur_req = "R11";
      thresh_i = 8'd200;
      wait_upd(); wait_upd();
      tick(8); check("R11 full duty high near end", ref_o, 1'b1);
      wait_upd(); tick(3);
      clr_pin_i = 1'b1; tick(1); clr_pin_i = 1'b0;
      tick(2); check("R11 cleared within period", ref_o, 1'b0);
      wait_upd();
      check("R11 low at overflow cycle", ref_o, 1'b0);
      tick(1); check("R11 high again after overflow", ref_o, 1'b1);
      tick(12);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule